// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Register Unit

This block holds the slot control and slot status registers of a downstream port that supports hot insertion and removal. Software reaches both registers through a small read/write port with byte enables. A second interface faces the slot. It carries insert and remove requests, an attention-button strobe, and a busy indication that refuses requests while the electromechanical interlock is engaged. A single event output reports when an enabled slot event is pending. That output feeds whatever logic produces the port's interrupt.

Every write that touches the control register is one command. Its side effects are a lock toggle, an orderly detach of a powered-down populated slot, and the command-completed status bit. All of them land one clock after the write is taken. The reset state of the power controller and power indicator follows the occupancy of the slot at power-up. That occupancy is given on the `boot_present` input and sampled while reset is held.

Top module: `hp_slot_unit`

## Requirements
- R1: A write with `reg_addr`=0 and any byte enable set is one command. The command-completed bit (status bit 2) is not yet set in the cycle after the write's edge and is set from the following edge on. A write with all byte enables clear does nothing.
- R2: Control bit 5 (lock toggle) always reads 0. Writing it as 1 with byte enable 0 set inverts the lock status bit (status bit 4) at the same edge that sets command-completed.
- R3: Synchronous reset (`rst_n` low at a clock edge) sets the attention indicator (control bits 1:0) to off (11). It clears the hot-plug interrupt enable (bit 6), the command-completed enable (bit 7), the presence-change enable (bit 8) and the button enable (bit 9).
- R4: Reset clears button-pressed (status bit 0), presence-changed (bit 1), command-completed (bit 2) and the lock status (bit 4). It sets presence state (bit 3) to `boot_present` and raises no event.
- R5: Status bits 0 to 2 are write-one-to-clear through `reg_addr`=1 with byte enable 0 set. Writes to status bits 3 and 4 are ignored. When a set and a clear of the same bit meet in one cycle, the set wins.
- R6: A control write with byte enable 0 set, power-off (bit 4) = 1 and power indicator (bits 3:2) = off (11), taken while presence state is 1, clears presence state and sets presence-changed one edge after the write. The same write with presence state 0 changes neither bit.
- R7: While the lock status is 1, `plug_busy` is high in any cycle with `insert_req` or `remove_req` high, and the request leaves presence state and presence-changed unchanged.
- R8: With the lock released, `insert_req` sets presence state and presence-changed at the next edge, and `remove_req` clears presence state and sets presence-changed. If both are high, the insert wins.
- R9: With `PWR_CTRL_EN`=1, reset sets power-off to the inverse of `boot_present` and sets the power indicator to on (01) when populated and off (11) when empty. With `PWR_CTRL_EN`=0, power-off reads 0, ignores writes, and the power indicator resets to off.
- R10: `hp_event` is high exactly when the hot-plug interrupt enable is 1 and at least one status event is set together with its own enable: command-completed with bit 7, presence-changed with bit 8, button-pressed with bit 9.
- R11: Control fields are updated only from written bytes. Bits 5:0 and bits 7:6 come from byte 0, and bits 9:8 come from byte 1.
- R12: A pulse on `btn_press` sets button-pressed at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_present | input | 1 | Slot occupancy at power-up, sampled during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects slot control, 1 selects slot status |
| reg_be | input | 2 | Byte enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| btn_press | input | 1 | Attention-button press strobe |
| insert_req | input | 1 | Slot-side request to insert a device |
| remove_req | input | 1 | Slot-side request to remove the device |
| plug_busy | output | 1 | Request refused because the interlock is engaged |
| hp_event | output | 1 | Enabled slot event pending |

## Verification
Control fields, write-one-to-clear results, button presses and insert or remove requests appear on `reg_rdata` after the edge that takes them. The command results arrive one edge later: command-completed, the lock toggle and the detach. `plug_busy` and `hp_event` follow their inputs and state in the same cycle. The bench drives inputs 2 ns after a rising edge and samples at the falling edge. Its behavioural model applies the same one-edge and two-edge delays. Directed checks read status in the cycle right after a command write to show that command-completed is not yet set, then read it again one cycle later.

// File: rtl/hp_slot_pkg.sv
`timescale 1ns/1ps
package hp_slot_pkg;

    typedef enum logic [1:0] {
        IND_RSVD  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_e;

    // slot control bit positions
    localparam int unsigned C_ATTN_LSB = 0;
    localparam int unsigned C_PIND_LSB = 2;
    localparam int unsigned C_PWR_OFF  = 4;
    localparam int unsigned C_LOCK_TGL = 5;
    localparam int unsigned C_HPIE     = 6;
    localparam int unsigned C_CCIE     = 7;
    localparam int unsigned C_PDCE     = 8;
    localparam int unsigned C_ABPE     = 9;
    localparam int unsigned C_TOP      = 9;

    // slot status bit positions
    localparam int unsigned S_ABP  = 0;
    localparam int unsigned S_PDC  = 1;
    localparam int unsigned S_CC   = 2;
    localparam int unsigned S_PDS  = 3;
    localparam int unsigned S_LOCK = 4;
    localparam int unsigned S_W1C_W = 3;

    typedef struct packed {
        ind_e attn;
        ind_e pind;
        logic pwr_off;
        logic hpie;
        logic ccie;
        logic pdce;
        logic abpe;
    } ctrl_t;

    typedef struct packed {
        logic abp;
        logic pdc;
        logic cc;
        logic pds;
        logic lock;
    } stat_t;

endpackage

// File: rtl/hp_slot_ctrl.sv
`timescale 1ns/1ps
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned PWR_CTRL_EN = 1,
    localparam int unsigned BE_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_present,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              present,
    output ctrl_t             ctrl,
    output logic              cmd_pulse,
    output logic              lock_tgl,
    output logic              detach
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  cmd;
        logic  tgl;
        logic  det;
    } cstate_t;

    cstate_t s_d, s_q;
    logic    pwr_off_rst;
    ind_e    pind_rst;
    logic    unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:C_TOP+1];

    generate
        if (PWR_CTRL_EN != 0) begin : g_pwr
            assign pwr_off_rst = ~boot_present;
            assign pind_rst    = boot_present ? IND_ON : IND_OFF;
        end else begin : g_nopwr
            assign pwr_off_rst = 1'b0;
            assign pind_rst    = IND_OFF;
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        s_d.cmd = 1'b0;
        s_d.tgl = 1'b0;
        s_d.det = 1'b0;
        if (wr_en && (|be)) begin
            s_d.cmd = 1'b1;
            if (be[0]) begin
                s_d.ctrl.attn = ind_e'(wdata[C_ATTN_LSB +: 2]);
                s_d.ctrl.pind = ind_e'(wdata[C_PIND_LSB +: 2]);
                if (PWR_CTRL_EN != 0) begin
                    s_d.ctrl.pwr_off = wdata[C_PWR_OFF];
                end
                s_d.ctrl.hpie = wdata[C_HPIE];
                s_d.ctrl.ccie = wdata[C_CCIE];
                s_d.tgl       = wdata[C_LOCK_TGL];
                s_d.det       = present && wdata[C_PWR_OFF]
                                && (wdata[C_PIND_LSB +: 2] == IND_OFF);
            end
            if (be[1]) begin
                s_d.ctrl.pdce = wdata[C_PDCE];
                s_d.ctrl.abpe = wdata[C_ABPE];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ctrl.attn    <= IND_OFF;
            s_q.ctrl.pind    <= pind_rst;
            s_q.ctrl.pwr_off <= pwr_off_rst;
            s_q.ctrl.hpie    <= 1'b0;
            s_q.ctrl.ccie    <= 1'b0;
            s_q.ctrl.pdce    <= 1'b0;
            s_q.ctrl.abpe    <= 1'b0;
            s_q.cmd          <= 1'b0;
            s_q.tgl          <= 1'b0;
            s_q.det          <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl      = s_q.ctrl;
    assign cmd_pulse = s_q.cmd;
    assign lock_tgl  = s_q.tgl;
    assign detach    = s_q.det;

    // detach and toggle only ever ride on a command
    assert_detach_is_command_R6: assert property (@(posedge clk) disable iff (!rst_n)
        detach |-> cmd_pulse);
    assert_toggle_is_command_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tgl |-> cmd_pulse);
    // a zero-enable write leaves every field alone
    assert_no_be_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(|be)) |=> $stable(ctrl));

endmodule

// File: rtl/hp_slot_status.sv
`timescale 1ns/1ps
module hp_slot_status
    import hp_slot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_present,
    input  logic               w1c_en,
    input  logic [S_W1C_W-1:0] w1c_bits,
    input  logic               cmd_pulse,
    input  logic               lock_tgl,
    input  logic               detach,
    input  logic               btn_press,
    input  logic               insert_req,
    input  logic               remove_req,
    output stat_t              stat,
    output logic               busy
);

    stat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (w1c_en) begin
            if (w1c_bits[S_ABP]) s_d.abp = 1'b0;
            if (w1c_bits[S_PDC]) s_d.pdc = 1'b0;
            if (w1c_bits[S_CC])  s_d.cc  = 1'b0;
        end
        if (cmd_pulse) s_d.cc   = 1'b1;
        if (lock_tgl)  s_d.lock = ~s_q.lock;
        if (detach) begin
            s_d.pds = 1'b0;
            s_d.pdc = 1'b1;
        end
        if (btn_press) s_d.abp = 1'b1;
        if (!s_q.lock) begin
            if (insert_req) begin
                s_d.pds = 1'b1;
                s_d.pdc = 1'b1;
            end else if (remove_req) begin
                s_d.pds = 1'b0;
                s_d.pdc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.abp  <= 1'b0;
            s_q.pdc  <= 1'b0;
            s_q.cc   <= 1'b0;
            s_q.pds  <= boot_present;
            s_q.lock <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat = s_q;
    assign busy = s_q.lock && (insert_req || remove_req);

    assert_cc_after_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse |=> stat.cc);
    assert_lock_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tgl |=> (stat.lock != $past(stat.lock)));
    assert_busy_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat.lock && (insert_req || remove_req)) |-> busy);
    assert_locked_keeps_presence_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat.lock && (insert_req || remove_req) && !detach) |=> $stable(stat.pds));
    assert_insert_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat.lock && insert_req) |=> (stat.pds && stat.pdc));
    assert_detach_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (detach && !(insert_req && !stat.lock)) |=> (!stat.pds && stat.pdc));
    assert_button_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
        btn_press |=> stat.abp);

endmodule

// File: rtl/hp_slot_event.sv
`timescale 1ns/1ps
module hp_slot_event
    import hp_slot_pkg::*;
(
    input  ctrl_t ctrl,
    input  stat_t stat,
    output logic  hp_event
);

    logic [2:0] src;

    always_comb begin
        src[0]   = stat.cc  && ctrl.ccie;
        src[1]   = stat.pdc && ctrl.pdce;
        src[2]   = stat.abp && ctrl.abpe;
        hp_event = ctrl.hpie && (|src);
    end

endmodule

// File: rtl/hp_slot_unit.sv
`timescale 1ns/1ps
module hp_slot_unit
    import hp_slot_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned PWR_CTRL_EN = 1,
    localparam int unsigned BE_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_present,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [BE_W-1:0]   reg_be,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              btn_press,
    input  logic              insert_req,
    input  logic              remove_req,
    output logic              plug_busy,
    output logic              hp_event
);

    ctrl_t ctrl;
    stat_t stat;
    logic  ctrl_wr;
    logic  stat_w1c;
    logic  cmd_pulse;
    logic  lock_tgl;
    logic  detach;

    assign ctrl_wr  = reg_wr && !reg_addr;
    assign stat_w1c = reg_wr && reg_addr && reg_be[0];

    hp_slot_ctrl #(
        .DATA_W      (DATA_W),
        .PWR_CTRL_EN (PWR_CTRL_EN)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_present (boot_present),
        .wr_en        (ctrl_wr),
        .be           (reg_be),
        .wdata        (reg_wdata),
        .present      (stat.pds),
        .ctrl         (ctrl),
        .cmd_pulse    (cmd_pulse),
        .lock_tgl     (lock_tgl),
        .detach       (detach)
    );

    hp_slot_status u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_present (boot_present),
        .w1c_en       (stat_w1c),
        .w1c_bits     (reg_wdata[S_W1C_W-1:0]),
        .cmd_pulse    (cmd_pulse),
        .lock_tgl     (lock_tgl),
        .detach       (detach),
        .btn_press    (btn_press),
        .insert_req   (insert_req),
        .remove_req   (remove_req),
        .stat         (stat),
        .busy         (plug_busy)
    );

    hp_slot_event u_evt (
        .ctrl     (ctrl),
        .stat     (stat),
        .hp_event (hp_event)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[S_ABP]  = stat.abp;
            reg_rdata[S_PDC]  = stat.pdc;
            reg_rdata[S_CC]   = stat.cc;
            reg_rdata[S_PDS]  = stat.pds;
            reg_rdata[S_LOCK] = stat.lock;
        end else begin
            reg_rdata[C_ATTN_LSB +: 2] = ctrl.attn;
            reg_rdata[C_PIND_LSB +: 2] = ctrl.pind;
            reg_rdata[C_PWR_OFF]       = ctrl.pwr_off;
            reg_rdata[C_HPIE]          = ctrl.hpie;
            reg_rdata[C_CCIE]          = ctrl.ccie;
            reg_rdata[C_PDCE]          = ctrl.pdce;
            reg_rdata[C_ABPE]          = ctrl.abpe;
        end
    end

    // a command write shows completion two edges later at the ports
    assert_write_completes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse |=> (stat.cc || !rst_n));
    // no event may be raised while the master enable is clear
    assert_event_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.hpie |-> !hp_event);

endmodule

// File: tb/tb_hp_slot_unit.sv
`timescale 1ns/1ps
module tb_hp_slot_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_present = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        btn_press = 1'b0;
    logic        insert_req = 1'b0;
    logic        remove_req = 1'b0;
    logic        plug_busy;
    logic        hp_event;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hp_slot_unit dut (
        .clk(clk), .rst_n(rst_n), .boot_present(boot_present),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .btn_press(btn_press), .insert_req(insert_req), .remove_req(remove_req),
        .plug_busy(plug_busy), .hp_event(hp_event)
    );

    // ---------------- behavioural model ----------------
    logic [1:0] m_attn, m_pind;
    bit m_poff, m_hpie, m_ccie, m_pdce, m_abpe;
    bit m_abp, m_pdc, m_cc, m_pds, m_lock;
    bit p_cmd, p_tgl, p_det;
    bit cur_pds, cur_lock, seen_rst = 0;

    function automatic logic [15:0] m_ctrl_word();
        return {6'b0, m_abpe, m_pdce, m_ccie, m_hpie, 1'b0, m_poff, m_pind, m_attn};
    endfunction

    function automatic logic [15:0] m_stat_word();
        return {11'b0, m_lock, m_pds, m_cc, m_pdc, m_abp};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_attn = 2'b11;
            m_pind = boot_present ? 2'b01 : 2'b11;
            m_poff = !boot_present;
            m_hpie = 0; m_ccie = 0; m_pdce = 0; m_abpe = 0;
            m_abp = 0; m_pdc = 0; m_cc = 0; m_lock = 0;
            m_pds = boot_present;
            p_cmd = 0; p_tgl = 0; p_det = 0;
            seen_rst = 1;
        end else begin
            cur_pds = m_pds;
            cur_lock = m_lock;
            if (reg_wr && reg_addr && reg_be[0]) begin
                if (reg_wdata[0]) m_abp = 0;
                if (reg_wdata[1]) m_pdc = 0;
                if (reg_wdata[2]) m_cc = 0;
            end
            if (p_cmd) m_cc = 1;
            if (p_tgl) m_lock = !m_lock;
            if (p_det) begin m_pds = 0; m_pdc = 1; end
            if (btn_press) m_abp = 1;
            if (!cur_lock) begin
                if (insert_req) begin m_pds = 1; m_pdc = 1; end
                else if (remove_req) begin m_pds = 0; m_pdc = 1; end
            end
            p_cmd = 0; p_tgl = 0; p_det = 0;
            if (reg_wr && !reg_addr && reg_be != 2'b00) begin
                p_cmd = 1;
                if (reg_be[0]) begin
                    m_attn = reg_wdata[1:0];
                    m_pind = reg_wdata[3:2];
                    m_poff = reg_wdata[4];
                    p_tgl  = reg_wdata[5];
                    m_hpie = reg_wdata[6];
                    m_ccie = reg_wdata[7];
                    p_det  = cur_pds && reg_wdata[4] && (reg_wdata[3:2] == 2'b11);
                end
                if (reg_be[1]) begin
                    m_pdce = reg_wdata[8];
                    m_abpe = reg_wdata[9];
                end
            end
        end
    end

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (rst_n && seen_rst && !done) begin
            logic [15:0] exp_rd;
            bit exp_evt, exp_busy;
            exp_rd   = reg_addr ? m_stat_word() : m_ctrl_word();
            exp_evt  = m_hpie && ((m_cc && m_ccie) || (m_pdc && m_pdce) || (m_abp && m_abpe));
            exp_busy = m_lock && (insert_req || remove_req);
            checks += 3;
            if (reg_rdata !== exp_rd) begin
                errors++;
                $display("FAIL R5 model register word addr=%0d actual=%h expected=%h", reg_addr, reg_rdata, exp_rd);
            end
            if (hp_event !== exp_evt) begin
                errors++;
                $display("FAIL R10 model hp_event actual=%0b expected=%0b", hp_event, exp_evt);
            end
            if (plug_busy !== exp_busy) begin
                errors++;
                $display("FAIL R7 model plug_busy actual=%0b expected=%0b", plug_busy, exp_busy);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic rd_now(input logic a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic a, input logic [1:0] be, input logic [15:0] d);
        step();
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = '0;
    endtask

    task automatic do_reset(input bit occupied);
        rst_n = 1'b0;
        boot_present = occupied;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset(1'b1);
        rd_now(1'b1, 16'h0008, "R4 status after reset, populated");
        chk("R4 no event after reset", {15'b0, hp_event}, 16'h0000);
        step();
        rd_now(1'b0, 16'h0007, "R3 R9 control after reset, populated");

        // command with toggle, all enables except byte1 fields
        wr(1'b0, 2'b11, 16'h00E5);
        rd_now(1'b1, 16'h0008, "R1 completion not yet visible");
        step();
        rd_now(1'b1, 16'h001C, "R1 R2 completion and lock set");
        chk("R10 event on completion", {15'b0, hp_event}, 16'h0001);
        step();
        rd_now(1'b0, 16'h00C5, "R2 toggle bit reads zero");

        // refused insert while locked
        step();
        insert_req = 1'b1;
        @(negedge clk);
        chk("R7 busy while locked", {15'b0, plug_busy}, 16'h0001);
        step();
        insert_req = 1'b0;
        rd_now(1'b1, 16'h001C, "R7 presence unchanged when locked");

        // write-one-to-clear
        wr(1'b1, 2'b01, 16'h0004);
        rd_now(1'b1, 16'h0018, "R5 clear completion");
        chk("R10 event drops", {15'b0, hp_event}, 16'h0000);
        wr(1'b1, 2'b01, 16'h001B);
        rd_now(1'b1, 16'h0018, "R5 presence and lock not writable");

        // toggle lock back
        wr(1'b0, 2'b01, 16'h00E5);
        step();
        rd_now(1'b1, 16'h000C, "R2 lock released by second toggle");

        // byte-1 only write
        wr(1'b0, 2'b10, 16'hFF00);
        rd_now(1'b0, 16'h03C5, "R11 byte1 only write");

        // remove, insert, button
        step(); remove_req = 1'b1;
        step(); remove_req = 1'b0;
        rd_now(1'b1, 16'h0006, "R8 removal");
        step(); insert_req = 1'b1;
        step(); insert_req = 1'b0;
        rd_now(1'b1, 16'h000E, "R8 insertion");
        step(); btn_press = 1'b1;
        step(); btn_press = 1'b0;
        rd_now(1'b1, 16'h000F, "R12 button pressed");
        chk("R10 event from button", {15'b0, hp_event}, 16'h0001);
        wr(1'b1, 2'b01, 16'h0007);
        rd_now(1'b1, 16'h0008, "R5 clear all events");

        // completion with its enable off: no event
        wr(1'b0, 2'b01, 16'h0045);
        step();
        rd_now(1'b1, 16'h000C, "R1 completion after enable change");
        chk("R10 completion masked by its enable", {15'b0, hp_event}, 16'h0000);
        wr(1'b1, 2'b01, 16'h0004);

        // detach of a populated slot
        wr(1'b0, 2'b01, 16'h00DD);
        step();
        rd_now(1'b1, 16'h0006, "R6 detach clears presence");
        step();
        rd_now(1'b0, 16'h03DD, "R6 control after detach write");

        // simultaneous requests
        step(); insert_req = 1'b1; remove_req = 1'b1;
        step(); insert_req = 1'b0; remove_req = 1'b0;
        rd_now(1'b1, 16'h000E, "R8 insert wins");

        // empty slot at power-up
        step();
        do_reset(1'b0);
        rd_now(1'b0, 16'h001F, "R9 control after reset, empty");
        step();
        rd_now(1'b1, 16'h0000, "R4 status after reset, empty");
        chk("R3 no event after reset", {15'b0, hp_event}, 16'h0000);
        wr(1'b0, 2'b01, 16'h00DD);
        step();
        rd_now(1'b1, 16'h0004, "R6 no detach when empty");
        step(); step();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule